// File: doc/BRIEF.md
# Edge-Coded Isolated Logic Link with Failsafe

This block is a cycle-level digital model of a one-bit isolated logic link. The sending half synchronises and filters the logic input, then emits a transition symbol each time the filtered level changes. It also emits a refresh symbol at a fixed period, and every symbol carries the current filtered level. The receiving half rebuilds the level from those symbols. It keeps a fast level that any symbol updates and a slow level that only refresh symbols update. While transitions have been seen recently the output follows the fast level; after a quiet interval it follows the slow, refresh-carried level.

A watchdog on the receiving half counts cycles since the last refresh. When refresh stops for the timeout, because the sending half lost power or the link went silent, the output is forced high. An input that is not driven also resolves high. After reset the output stays high until the first refresh arrives. When refresh resumes, the first refresh ends the failsafe state and the output takes the level that refresh carries. All time constants are counts of one sampling clock.

Top module: `edge_iso_link`

## Requirements
- R1: During reset and after it, until the first refresh reaches the receiver, `dout` is 1 and `failsafe` is 1.
- R2: The first refresh after reset clears `failsafe`, and in that same cycle `dout` shows the input level that refresh carries.
- R3: An input level held for at least FILT_LEN clock cycles reaches `dout` exactly SYNC_STAGES + FILT_LEN + 2 cycles after it is first sampled. The delay is the same for rising and falling changes.
- R4: An input pulse shorter than FILT_LEN cycles, of either polarity, never changes `dout`.
- R5: `path_fast` goes to 1 in the same cycle that a transition reaches `dout`. It returns to 0 after ACT_HOLD cycles without transitions, and `dout` does not change when it does.
- R6: While the sending half is powered and the input is static, `failsafe` stays 0 for any length of time (REFRESH_PERIOD at most half of TIMEOUT).
- R7: With `tx_pwr` at 0, `failsafe` rises and `dout` reads 1 whatever `din` does.
- R8: With `in_drive` at 0 (input open), the link carries a 1: `dout` is 1 and `failsafe` stays 0.
- R9: After a failsafe event, restoring `tx_pwr` ends `failsafe` at the first refresh, within REFRESH_PERIOD + 4 cycles, and `dout` takes the refreshed level in that cycle.
- R10: After power is lost, `failsafe` rises no sooner than TIMEOUT - REFRESH_PERIOD cycles and no later than TIMEOUT + 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for both halves |
| rst | input | 1 | Synchronous active-high reset |
| tx_pwr | input | 1 | Sending half powered (1) or down (0) |
| in_drive | input | 1 | Input actively driven (1) or open (0, reads high) |
| din | input | 1 | Logic input level |
| dout | output | 1 | Rebuilt output level, registered |
| failsafe | output | 1 | Loss-of-refresh state, output forced high |
| path_fast | output | 1 | 1 while the transition path drives `dout` |

## Verification
A stuck or skipped filter counter shows up at once at the ports. The rise or fall delay moves away from SYNC_STAGES + FILT_LEN + 2 cycles, or a short pulse reaches `dout`. A wrong watchdog count or refresh timer shows up within about one TIMEOUT: `failsafe` either fires while the input is static and powered, or fires outside its window after power is lost. A wrong choice between the fast and slow levels is visible only when `path_fast` drops, ACT_HOLD cycles after the last transition, as a step in `dout` at that cycle.

// File: rtl/iso_link_pkg.sv
package iso_link_pkg;

  // Symbol kinds on the narrow link. Bit 0 marks a transition and bit 1
  // marks a refresh, so the encoder builds the kind from those two flags.
  typedef enum logic [1:0] {
    SYM_NONE    = 2'b00,
    SYM_EDGE    = 2'b01,
    SYM_REFRESH = 2'b10,
    SYM_BOTH    = 2'b11
  } sym_kind_e;

  typedef struct packed {
    sym_kind_e kind;
    logic      level;
  } link_sym_t;

  function automatic logic sym_has_edge(link_sym_t s);
    return (s.kind == SYM_EDGE) || (s.kind == SYM_BOTH);
  endfunction

  function automatic logic sym_has_refresh(link_sym_t s);
    return (s.kind == SYM_REFRESH) || (s.kind == SYM_BOTH);
  endfunction

endpackage

// File: rtl/iso_glitch_filter.sv
module iso_glitch_filter #(
  parameter int FILT_LEN    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic level_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   level_q;
  logic                   samp;

  assign samp    = sync_q[SYNC_STAGES-1];
  assign level_o = level_q;

  // The idle level is high, which matches the failsafe value.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '1;
      run_q   <= '0;
      level_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      if (samp != level_q) begin
        if (run_q == CW'(FILT_LEN - 1)) begin
          level_q <= samp;
          run_q   <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  // A change of the filtered level needs the sampled input at the new
  // value for at least the two cycles before it.
  generate
    if (FILT_LEN >= 2) begin : g_filt_chk
      p_filter_settled_r4: assert property (@(posedge clk) disable iff (rst)
        (level_q != $past(level_q)) |-> ($past(samp) == level_q && $past(samp, 2) == level_q));
    end
  endgenerate

endmodule

// File: rtl/iso_tx_encoder.sv
module iso_tx_encoder
  import iso_link_pkg::*;
#(
  parameter int REFRESH_PERIOD = 1000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pwr_i,
  input  logic      level_i,
  output link_sym_t sym_o
);
  localparam int RW = $clog2(REFRESH_PERIOD + 1);

  logic [RW-1:0] ref_cnt_q;
  logic          last_q;
  link_sym_t     sym_q;
  logic          due;
  logic          edge_now;

  assign due      = (ref_cnt_q == RW'(REFRESH_PERIOD - 1));
  assign edge_now = (level_i != last_q);
  assign sym_o    = sym_q;

  always_ff @(posedge clk) begin
    if (rst || !pwr_i) begin
      ref_cnt_q  <= '0;
      last_q     <= level_i;
      sym_q.kind <= SYM_NONE;
      sym_q.level <= 1'b1;
    end else begin
      ref_cnt_q   <= due ? '0 : ref_cnt_q + 1'b1;
      last_q      <= level_i;
      sym_q.kind  <= sym_kind_e'({due, edge_now});
      sym_q.level <= level_i;
    end
  end

  p_edge_emits_r3: assert property (@(posedge clk) disable iff (rst)
    (pwr_i && edge_now) |=> (sym_has_edge(sym_q) && sym_q.level == $past(level_i)));

  p_quiet_unpowered_r7: assert property (@(posedge clk) disable iff (rst)
    !pwr_i |=> (sym_q.kind == SYM_NONE));

  generate
    if (REFRESH_PERIOD >= 2) begin : g_ref_chk
      p_refresh_spaced_r6: assert property (@(posedge clk) disable iff (rst)
        sym_has_refresh(sym_q) |=> !sym_has_refresh(sym_q));
    end
  endgenerate

endmodule

// File: rtl/iso_rx_decoder.sv
module iso_rx_decoder
  import iso_link_pkg::*;
#(
  parameter int TIMEOUT  = 4000,
  parameter int ACT_HOLD = 2000
) (
  input  logic      clk,
  input  logic      rst,
  input  link_sym_t sym_i,
  output logic      dout_o,
  output logic      failsafe_o,
  output logic      path_fast_o
);
  localparam int WW = $clog2(TIMEOUT + 1);
  localparam int AW = $clog2(ACT_HOLD + 1);

  logic [WW-1:0] wd_q, wd_d;
  logic [AW-1:0] act_q, act_d;
  logic          fast_lvl_q, fast_lvl_d;
  logic          slow_lvl_q, slow_lvl_d;
  logic          fs_q, fs_d;
  logic          sel_fast_q, sel_fast_d;
  logic          dout_q, dout_d;
  logic          got_edge, got_ref;

  assign got_edge = sym_has_edge(sym_i);
  assign got_ref  = sym_has_refresh(sym_i);

  always_comb begin
    // Loss-of-refresh watchdog, saturating at the timeout.
    if (got_ref) begin
      wd_d = '0;
      fs_d = 1'b0;
    end else if (wd_q == WW'(TIMEOUT - 1)) begin
      wd_d = wd_q;
      fs_d = 1'b1;
    end else begin
      wd_d = wd_q + 1'b1;
      fs_d = fs_q;
    end

    // Fast level follows every symbol, slow level only refreshes.
    fast_lvl_d = (sym_i.kind != SYM_NONE) ? sym_i.level : fast_lvl_q;
    slow_lvl_d = got_ref ? sym_i.level : slow_lvl_q;

    // Activity window that selects the fast path.
    if (got_edge)        act_d = AW'(ACT_HOLD);
    else if (act_q != 0) act_d = act_q - 1'b1;
    else                 act_d = act_q;
    sel_fast_d = (act_d != 0);

    if (fs_d)            dout_d = 1'b1;
    else if (sel_fast_d) dout_d = fast_lvl_d;
    else                 dout_d = slow_lvl_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_q       <= '0;
      act_q      <= '0;
      fast_lvl_q <= 1'b1;
      slow_lvl_q <= 1'b1;
      fs_q       <= 1'b1;
      sel_fast_q <= 1'b0;
      dout_q     <= 1'b1;
    end else begin
      wd_q       <= wd_d;
      act_q      <= act_d;
      fast_lvl_q <= fast_lvl_d;
      slow_lvl_q <= slow_lvl_d;
      fs_q       <= fs_d;
      sel_fast_q <= sel_fast_d;
      dout_q     <= dout_d;
    end
  end

  assign dout_o      = dout_q;
  assign failsafe_o  = fs_q;
  assign path_fast_o = sel_fast_q;

  p_fs_output_high_r7: assert property (@(posedge clk) disable iff (rst)
    fs_q |-> dout_q);

  p_refresh_clears_fs_r9: assert property (@(posedge clk) disable iff (rst)
    got_ref |=> !fs_q);

  p_release_level_r2: assert property (@(posedge clk) disable iff (rst)
    (fs_q != $past(fs_q) && !fs_q) |-> (dout_q == $past(sym_i.level)));

  p_fast_after_edge_r5: assert property (@(posedge clk) disable iff (rst)
    got_edge |=> sel_fast_q);

endmodule

// File: rtl/edge_iso_link.sv
module edge_iso_link
  import iso_link_pkg::*;
#(
  parameter int FILT_LEN       = 3,
  parameter int SYNC_STAGES    = 2,
  parameter int REFRESH_PERIOD = 1000,
  parameter int TIMEOUT        = 4000,
  parameter int ACT_HOLD       = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_pwr,
  input  logic in_drive,
  input  logic din,
  output logic dout,
  output logic failsafe,
  output logic path_fast
);
  logic      raw_level;
  logic      tx_rst;
  logic      filt_level;
  link_sym_t link_sym;

  // An undriven input is pulled high; a powered-down sender is held idle.
  assign raw_level = in_drive ? din : 1'b1;
  assign tx_rst    = rst || !tx_pwr;

  iso_glitch_filter #(
    .FILT_LEN    (FILT_LEN),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_filter (
    .clk     (clk),
    .rst     (tx_rst),
    .raw_i   (raw_level),
    .level_o (filt_level)
  );

  iso_tx_encoder #(
    .REFRESH_PERIOD (REFRESH_PERIOD)
  ) u_tx (
    .clk     (clk),
    .rst     (rst),
    .pwr_i   (tx_pwr),
    .level_i (filt_level),
    .sym_o   (link_sym)
  );

  iso_rx_decoder #(
    .TIMEOUT  (TIMEOUT),
    .ACT_HOLD (ACT_HOLD)
  ) u_rx (
    .clk         (clk),
    .rst         (rst),
    .sym_i       (link_sym),
    .dout_o      (dout),
    .failsafe_o  (failsafe),
    .path_fast_o (path_fast)
  );

  p_open_input_high_r8: assert property (@(posedge clk) disable iff (rst)
    (!in_drive && tx_pwr) |=> (u_filter.sync_q[0] == 1'b1));

endmodule

// File: tb/edge_iso_link_bench.sv
module edge_iso_link_bench;
  localparam int FILT  = 3;
  localparam int SYNC  = 2;
  localparam int RP    = 16;
  localparam int TO    = 40;
  localparam int AH    = 24;
  localparam int LAT   = SYNC + FILT + 2;
  localparam int WDOG  = 20000;

  // Vector entry: [11] in_drive, [10] din, [9] expected dout, [8:0] hold cycles
  localparam int NVEC = 8;
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b1, 9'd20},
    {1'b1, 1'b0, 1'b0, 9'd20},
    {1'b0, 1'b0, 1'b1, 9'd20},
    {1'b0, 1'b1, 1'b1, 9'd20},
    {1'b1, 1'b0, 1'b0, 9'd20},
    {1'b1, 1'b1, 1'b1, 9'd40},
    {1'b0, 1'b0, 1'b1, 9'd40},
    {1'b1, 1'b0, 1'b0, 9'd40}
  };

  logic clk = 1'b0;
  logic rst, tx_pwr, in_drive, din;
  logic dout, failsafe, path_fast;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  edge_iso_link #(
    .FILT_LEN (FILT), .SYNC_STAGES (SYNC), .REFRESH_PERIOD (RP),
    .TIMEOUT (TO), .ACT_HOLD (AH)
  ) u_edge_iso_link (
    .clk (clk), .rst (rst), .tx_pwr (tx_pwr), .in_drive (in_drive),
    .din (din), .dout (dout), .failsafe (failsafe), .path_fast (path_fast)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive din at a negedge and count negedges until dout follows.
  task automatic measure(input logic v, output int lat);
    din = v;
    lat = 0;
    while (dout !== v && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lat, n;
    bit seen;
    rst = 1'b1; tx_pwr = 1'b1; in_drive = 1'b1; din = 1'b0;
    tick(5);
    chk(dout === 1'b1 && failsafe === 1'b1, "R1 in reset", dout, 1);
    rst = 1'b0;
    tick(5);
    chk(dout === 1'b1 && failsafe === 1'b1, "R1 before first refresh", failsafe, 1);

    // R2: first refresh releases failsafe with the carried level
    n = 0;
    while (failsafe === 1'b1 && n < 100) begin tick(1); n++; end
    chk(failsafe === 1'b0 && n <= RP + 4, "R2 release time", n, RP + 4);
    chk(dout === 1'b0, "R2 level at release", dout, 0);

    // Vector table: R3 levels and R8 open input
    for (int i = 0; i < NVEC; i++) begin
      in_drive = VEC[i][11];
      din      = VEC[i][10];
      tick(int'(VEC[i][8:0]));
      chk(dout === VEC[i][9], (VEC[i][11] ? "R3 vector" : "R8 open input"),
          dout, int'(VEC[i][9]));
      chk(failsafe === 1'b0, "R8 no failsafe in vector", failsafe, 0);
    end

    // R3: equal rise and fall latency
    tick(AH + 5);
    measure(1'b1, lat);
    chk(lat == LAT, "R3 rise latency", lat, LAT);
    chk(path_fast === 1'b1, "R5 fast on transition", path_fast, 1);
    tick(20);
    measure(1'b0, lat);
    chk(lat == LAT, "R3 fall latency", lat, LAT);

    // R5: fast path times out without a step in dout
    tick(AH + 5);
    chk(path_fast === 1'b0 && dout === 1'b0, "R5 slow after idle", path_fast, 0);

    // R4: short high pulse while low
    din = 1'b1; tick(FILT - 1); din = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 25; k++) begin tick(1); if (dout !== 1'b0) seen = 1'b1; end
    chk(!seen, "R4 short high pulse", seen, 0);
    // R3: pulse of exactly FILT cycles passes
    din = 1'b1; tick(FILT); din = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 25; k++) begin tick(1); if (dout === 1'b1) seen = 1'b1; end
    chk(seen, "R3 minimum pulse passes", seen, 1);
    // R4: short low pulse while high
    din = 1'b1; tick(30);
    din = 1'b0; tick(FILT - 1); din = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 25; k++) begin tick(1); if (dout !== 1'b1) seen = 1'b1; end
    chk(!seen, "R4 short low pulse", seen, 0);

    // R6: static input, powered, long run
    din = 1'b0; tick(20);
    seen = 1'b0;
    for (int k = 0; k < 10 * TO; k++) begin tick(1); if (failsafe !== 1'b0) seen = 1'b1; end
    chk(!seen, "R6 no failsafe when refreshed", seen, 0);

    // R7 and R10: power loss
    tx_pwr = 1'b0;
    n = 0;
    while (failsafe !== 1'b1 && n < 200) begin tick(1); n++; end
    chk(n >= TO - RP && n <= TO + 2, "R10 failsafe window", n, TO);
    chk(dout === 1'b1, "R7 output high when unpowered", dout, 1);
    din = 1'b1; tick(10); din = 1'b0; tick(10);
    chk(dout === 1'b1 && failsafe === 1'b1, "R7 din ignored when unpowered", dout, 1);

    // R9: recovery
    tx_pwr = 1'b1;
    n = 0;
    while (failsafe === 1'b1 && n < 100) begin tick(1); n++; end
    chk(failsafe === 1'b0 && n <= RP + 4, "R9 recovery time", n, RP + 4);
    chk(dout === 1'b0, "R9 level at recovery", dout, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule